// File: doc/BRIEF.md
# Paged external memory expansion unit

This block lets a processor with a 16-bit address space reach a larger external 16-bit SRAM through a paged window. Four 8-bit page registers are loaded and read back over the processor's I/O register port. Writes use one I/O address range and reads use another. During an access to the expansion window, the two top CPU address bits pick one page register. That register's value drives the upper external address lines.

The page lines are qualified by a copy of the expansion chip-select that is delayed by one clock. They therefore stay at zero while no access is in progress. The block also drives the SRAM's low-byte and high-byte lane enables and a single write strobe. The write strobe is the AND of the two active-low per-byte write strobes. All of this external behaviour is enabled only while the 3-bit memory-configuration mode field holds the extended-memory code 3'b111.

Top module: `page_xmem_unit`

## Requirements
- R1: While `rst_ni` is low, all four page registers clear to 0x00. `xpage_o` reads 0x00, `we_no`, `lb_no` and `ub_no` read 1, and the delayed chip-select is cleared.
- R2: An I/O write with `io_wr_i` high at address 0xFBF2 + 2n (n = 0..3) loads `io_wdata_i` into page register n on that rising edge, in any mode. While `io_rd_i` is high at address 0xFF9E + 2n, `io_rdata_o` shows register n in the same cycle.
- R3: I/O writes to any other address are ignored. This covers odd addresses, 0xFBFA, and the read range. A read at an address outside the read range, or with `io_rd_i` low, returns 0x00.
- R4: Bits [16:15] of `cpu_addr_i` select the page register: 2'b00 gives register 0, 2'b01 register 1, 2'b10 register 2 and 2'b11 register 3.
- R5: `xpage_o` equals the selected register only when `xcs_i` was high with mode 3'b111 at the previous rising edge. Otherwise it is 0x00. A rise or fall of `xcs_i` therefore reaches `xpage_o` one cycle later.
- R6: `we_no` is the AND of `wr_ni[0]` and `wr_ni[1]` while `xcs_i` is high and mode is 3'b111. It goes low when either byte is written.
- R7: `lb_no` is low exactly when `wr_ni[0]` is low, and `ub_no` is low exactly when `wr_ni[1]` is low, with `xcs_i` high and mode 3'b111. A word write (`wr_ni` = 2'b00) drives both low.
- R8: While mode is not 3'b111, `we_no`, `lb_no` and `ub_no` stay 1 and `xpage_o` stays 0x00, whatever `xcs_i` and `wr_ni` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Memory-configuration mode field |
| io_addr_i | input | 16 | I/O register address |
| io_wr_i | input | 1 | I/O write enable |
| io_wdata_i | input | 8 | I/O write data |
| io_rd_i | input | 1 | I/O read enable |
| io_rdata_o | output | 8 | I/O read data (combinational) |
| cpu_addr_i | input | 17 | CPU expansion address; bits [16:15] pick the page |
| xcs_i | input | 1 | Expansion chip-select, active high |
| wr_ni | input | 2 | Per-byte write strobes, active low ([0] low byte) |
| xpage_o | output | 8 | Upper external address lines |
| we_no | output | 1 | SRAM write strobe, active low |
| lb_no | output | 1 | Low-byte lane enable, active low |
| ub_no | output | 1 | High-byte lane enable, active low |

## Verification
The strobes and the read-back data are combinational. They are due in the same cycle as the stimulus, so the bench drives inputs on the falling edge and samples them a quarter period later. A page-register write takes effect at the next rising edge. The page lines follow the chip-select one rising edge late. The bench checks that both values hold off before that edge and appear just after it, and it does the same for the trailing edge of the chip-select.

// File: rtl/pxm_pkg.sv
package pxm_pkg;
  localparam int unsigned PAGE_W  = 8;
  localparam int unsigned N_PAGES = 4;
  localparam int unsigned IO_AW   = 16;
  localparam int unsigned CPU_AW  = 17;
  localparam int unsigned MODE_W  = 3;
  localparam logic [MODE_W-1:0] MODE_EXT = 3'b111;
  localparam logic [IO_AW-1:0]  WR_BASE  = 16'hFBF2;
  localparam logic [IO_AW-1:0]  RD_BASE  = 16'hFF9E;
endpackage

// File: rtl/pxm_page_regs.sv
module pxm_page_regs #(
  parameter int unsigned N   = 4,
  parameter int unsigned W   = 8,
  parameter int unsigned AW  = 16,
  parameter logic [AW-1:0] WR_BASE = '0,
  parameter logic [AW-1:0] RD_BASE = '0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  io_addr_i,
  input  logic           io_wr_i,
  input  logic [W-1:0]   io_wdata_i,
  input  logic           io_rd_i,
  output logic [W-1:0]   io_rdata_o,
  output logic [N*W-1:0] pages_o
);
  logic [N-1:0] wr_hit, rd_hit;
  logic [W-1:0] page_q [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    localparam logic [AW-1:0] WA = WR_BASE + AW'(2 * i);
    localparam logic [AW-1:0] RA = RD_BASE + AW'(2 * i);
    assign wr_hit[i] = io_wr_i && (io_addr_i == WA);
    assign rd_hit[i] = io_rd_i && (io_addr_i == RA);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        page_q[i] <= '0;
      else if (wr_hit[i]) page_q[i] <= io_wdata_i;
    end

    assign pages_o[i*W +: W] = page_q[i];
  end

  always_comb begin
    io_rdata_o = '0;
    for (int i = 0; i < N; i++)
      if (rd_hit[i]) io_rdata_o = page_q[i];
  end
endmodule

// File: rtl/pxm_page_sel.sv
module pxm_page_sel #(
  parameter int unsigned N     = 4,
  parameter int unsigned W     = 8,
  parameter int unsigned SEL_W = $clog2(N)
) (
  input  logic [N*W-1:0]   pages_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             gate_i,
  output logic [W-1:0]     page_o
);
  logic [W-1:0] picked;
  assign picked = pages_i[sel_i*W +: W];
  assign page_o = picked & {W{gate_i}};
endmodule

// File: rtl/pxm_strobe_gen.sv
module pxm_strobe_gen #(
  parameter int unsigned MODE_W = 3,
  parameter logic [MODE_W-1:0] MODE_EXT = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              xcs_i,
  input  logic [1:0]        wr_ni,
  output logic              page_gate_o,
  output logic              we_no,
  output logic              lb_no,
  output logic              ub_no
);
  logic mode_ok, active, cs_q;

  assign mode_ok = (mode_i == MODE_EXT);
  assign active  = mode_ok && xcs_i;

  // one-cycle delayed chip-select qualifies the page lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= 1'b0;
    else         cs_q <= active;
  end

  assign page_gate_o = cs_q && mode_ok;
  assign lb_no = ~(active && !wr_ni[0]);
  assign ub_no = ~(active && !wr_ni[1]);
  assign we_no = active ? (wr_ni[0] & wr_ni[1]) : 1'b1;
endmodule

// File: rtl/page_xmem_unit.sv
module page_xmem_unit
  import pxm_pkg::*;
#(
  parameter int unsigned PW  = PAGE_W,
  parameter int unsigned NP  = N_PAGES,
  parameter int unsigned AW  = IO_AW,
  parameter int unsigned CAW = CPU_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [AW-1:0]     io_addr_i,
  input  logic              io_wr_i,
  input  logic [PW-1:0]     io_wdata_i,
  input  logic              io_rd_i,
  output logic [PW-1:0]     io_rdata_o,
  input  logic [CAW-1:0]    cpu_addr_i,
  input  logic              xcs_i,
  input  logic [1:0]        wr_ni,
  output logic [PW-1:0]     xpage_o,
  output logic              we_no,
  output logic              lb_no,
  output logic              ub_no
);
  localparam int unsigned SEL_W = $clog2(NP);

  logic [NP*PW-1:0] pages;
  logic             page_gate;

  pxm_page_regs #(
    .N(NP), .W(PW), .AW(AW), .WR_BASE(WR_BASE), .RD_BASE(RD_BASE)
  ) u_regs (
    .clk_i, .rst_ni, .io_addr_i, .io_wr_i, .io_wdata_i, .io_rd_i,
    .io_rdata_o, .pages_o(pages)
  );

  pxm_strobe_gen #(.MODE_W(MODE_W), .MODE_EXT(MODE_EXT)) u_strb (
    .clk_i, .rst_ni, .mode_i, .xcs_i, .wr_ni,
    .page_gate_o(page_gate), .we_no, .lb_no, .ub_no
  );

  pxm_page_sel #(.N(NP), .W(PW), .SEL_W(SEL_W)) u_sel (
    .pages_i(pages), .sel_i(cpu_addr_i[CAW-1 -: SEL_W]),
    .gate_i(page_gate), .page_o(xpage_o)
  );
endmodule

// File: rtl/page_xmem_chk.sv
module page_xmem_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_i,
  input logic       xcs_i,
  input logic [1:0] wr_ni,
  input logic       io_rd_i,
  input logic [7:0] io_rdata_o,
  input logic [7:0] xpage_o,
  input logic       we_no,
  input logic       lb_no,
  input logic       ub_no
);
  logic prev_act;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_act <= 1'b0;
    else         prev_act <= xcs_i && (mode_i == 3'b111);
  end

  // R5
  page_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prev_act |-> xpage_o == 8'h00);

  // R8
  mode_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i != 3'b111 |-> (we_no && lb_no && ub_no && xpage_o == 8'h00));

  // R6
  we_follows_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_no == (lb_no && ub_no));

  // R7
  low_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xcs_i && mode_i == 3'b111 && !wr_ni[0]) |-> !lb_no);

  // R7
  high_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xcs_i && mode_i == 3'b111 && !wr_ni[1]) |-> !ub_no);

  // R3
  rd_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |-> io_rdata_o == 8'h00);
endmodule

bind page_xmem_unit page_xmem_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .xcs_i(xcs_i),
  .wr_ni(wr_ni), .io_rd_i(io_rd_i), .io_rdata_o(io_rdata_o),
  .xpage_o(xpage_o), .we_no(we_no), .lb_no(lb_no), .ub_no(ub_no)
);

// File: tb/tb_page_xmem_unit.sv
module tb_page_xmem_unit;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0]  mode_i = 3'b111;
  logic [15:0] io_addr_i = '0;
  logic        io_wr_i = 1'b0, io_rd_i = 1'b0;
  logic [7:0]  io_wdata_i = '0;
  logic [7:0]  io_rdata_o, xpage_o;
  logic [16:0] cpu_addr_i = '0;
  logic        xcs_i = 1'b0;
  logic [1:0]  wr_ni = 2'b11;
  logic        we_no, lb_no, ub_no;

  int total = 0, bad = 0;

  page_xmem_unit dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  // {mode[2:0], cs, wr_n[1:0], we_n, lb_n, ub_n}
  localparam int NV = 9;
  localparam logic [8:0] VEC [NV] = '{
    {3'b111, 1'b1, 2'b11, 3'b111},
    {3'b111, 1'b1, 2'b10, 3'b001},
    {3'b111, 1'b1, 2'b01, 3'b010},
    {3'b111, 1'b1, 2'b00, 3'b000},
    {3'b111, 1'b0, 2'b00, 3'b111},
    {3'b011, 1'b1, 2'b00, 3'b111},
    {3'b000, 1'b1, 2'b10, 3'b111},
    {3'b110, 1'b1, 2'b01, 3'b111},
    {3'b101, 1'b0, 2'b00, 3'b111}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    io_addr_i = a; io_wdata_i = d; io_wr_i = 1'b1;
    @(negedge clk_i);
    io_wr_i = 1'b0;
  endtask

  task automatic io_read(input string req, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk_i);
    io_addr_i = a; io_rd_i = 1'b1;
    #(CLK_P/4);
    check(req, io_rdata_o, exp);
    io_rd_i = 1'b0;
  endtask

  initial begin
    #(CLK_P*20000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    xcs_i = 1'b1; wr_ni = 2'b11;
    #(CLK_P*2 + CLK_P/4);
    check("R1 page", xpage_o, 8'h00);
    check("R1 strobes", {we_no, lb_no, ub_no}, 3'b111);
    @(negedge clk_i); xcs_i = 1'b0; rst_ni = 1'b1;

    // strobe table: R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {mode_i, xcs_i, wr_ni} = VEC[i][8:3];
      #(CLK_P/4);
      check(VEC[i][8:6] == 3'b111 ? "R6/R7 strobes" : "R8 strobes",
            {we_no, lb_no, ub_no}, VEC[i][2:0]);
    end
    @(negedge clk_i); mode_i = 3'b111; xcs_i = 1'b0; wr_ni = 2'b11;

    // R1 registers read zero after reset
    io_read("R1 reg0", 16'hFF9E, 8'h00);

    // R2 write/read all four registers
    for (int n = 0; n < 4; n++) io_write(16'hFBF2 + 16'(2*n), 8'hA0 + 8'(n * 17));
    for (int n = 0; n < 4; n++) io_read("R2 readback", 16'hFF9E + 16'(2*n), 8'hA0 + 8'(n * 17));

    // R2 write works in another mode
    mode_i = 3'b010;
    io_write(16'hFBF4, 8'h5C);
    io_read("R2 write mode off", 16'hFFA0, 8'h5C);
    mode_i = 3'b111;

    // R3 ignored writes
    io_write(16'hFBF3, 8'hEE);
    io_write(16'hFBFA, 8'hEE);
    io_write(16'hFF9E, 8'hEE);
    io_write(16'hFBF0, 8'hEE);
    io_read("R3 reg0 kept", 16'hFF9E, 8'hA0);
    io_read("R3 reg1 kept", 16'hFFA0, 8'h5C);
    io_read("R3 reg2 kept", 16'hFFA2, 8'hC2);
    io_read("R3 reg3 kept", 16'hFFA4, 8'hD3);
    io_read("R3 odd read", 16'hFF9F, 8'h00);
    io_read("R3 out of range", 16'hFFA6, 8'h00);
    io_read("R3 write addr read", 16'hFBF2, 8'h00);

    // R5 delayed chip-select
    @(negedge clk_i);
    cpu_addr_i = 17'h10000; xcs_i = 1'b1;
    #(CLK_P/4);
    check("R5 before edge", xpage_o, 8'h00);
    @(negedge clk_i); #(CLK_P/4);
    check("R5 after edge", xpage_o, 8'hC2);

    // R4 selection by bits 16:15
    for (int s = 0; s < 4; s++) begin
      logic [7:0] expv;
      @(negedge clk_i);
      cpu_addr_i = {s[1:0], 15'h1234};
      expv = (s == 0) ? 8'hA0 : (s == 1) ? 8'h5C : (s == 2) ? 8'hC2 : 8'hD3;
      #(CLK_P/4);
      check("R4 select", xpage_o, expv);
    end

    // R5 trailing edge
    @(negedge clk_i); xcs_i = 1'b0;
    #(CLK_P/4);
    check("R5 hold after cs drop", xpage_o, 8'hD3);
    @(negedge clk_i); #(CLK_P/4);
    check("R5 cleared", xpage_o, 8'h00);

    // R8 mode off blocks the page lines
    @(negedge clk_i); xcs_i = 1'b1; mode_i = 3'b100; wr_ni = 2'b00;
    @(negedge clk_i); #(CLK_P/4);
    check("R8 page", xpage_o, 8'h00);
    check("R8 strobes", {we_no, lb_no, ub_no}, 3'b111);
    mode_i = 3'b111;
    #(CLK_P/8);
    check("R8 page still gated", xpage_o, 8'h00);

    // R1 async reset clears registers
    @(negedge clk_i); xcs_i = 1'b0; wr_ni = 2'b11; rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    io_read("R1 reset clears reg3", 16'hFFA4, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule